// File: doc/BRIEF.md
# DMA Transfer Termination Controller

This block runs the device side of a DMA transfer between a host DMA engine and one bulk endpoint FIFO. When software sets the enable bit, the block copies the programmed byte length into a down-counter and raises the request line towards the host. Each accepted data strobe lowers the count by the bus width, which is one or two bytes. The strobe comes either from the acknowledge line combined with the direction's read or write line, or, in acknowledge-only mode, from the acknowledge line alone.

Four events can end a transfer: software clearing the enable bit, an edge on the asynchronous external end-of-transfer input, the counter reaching zero while count termination is enabled, and a short packet arriving on an OUT endpoint while short-packet termination is enabled. When more than one fires in the same cycle, only the highest-priority one takes effect. The block drops the request, records the cause in a sticky status field and then gives the FIFO a one-cycle command. On an OUT endpoint that command flushes only the active buffer. On an IN endpoint it commits the partly filled packet for sending.

Top module: `dma_eot_ctrl`

## Requirements
- R1: After reset, dreq, data_strobe, fifo_flush, pkt_commit and flush_buf are 0, eot_cause is 0 and cnt_left is 0.
- R2: A rising edge of cfg_dma_en loads xfer_len into cnt_left and raises dreq at the following clock edge. A later enable reloads the counter.
- R3: Each beat lowers cnt_left by 1 when cfg_wide=0 or by 2 when cfg_wide=1, and the count saturates at 0.
- R4: A beat is a rising edge of the selected strobe during a transfer. With cfg_ack_strobe=1 the strobe is dack alone and host_rd and host_wr are ignored. With cfg_ack_strobe=0 the strobe is dack AND host_rd for OUT (cfg_dir_in=0), or dack AND host_wr for IN (cfg_dir_in=1).
- R5: With cfg_cnt_en=1, a transfer ends when cnt_left is 0, and a length of 0 ends it right after enable. With cfg_cnt_en=0 a zero count ends nothing.
- R6: A rising edge on ext_eot ends the transfer once, however long the input stays high. For OUT it pulses fifo_flush with flush_buf one-hot on the active buffer: bit act_buf when dbl_buf=1, otherwise bit 0. For IN it pulses pkt_commit.
- R7: short_pkt ends an OUT transfer only when cfg_short_en=1. It is ignored for IN or when cfg_short_en=0. It causes no flush and no commit.
- R8: Clearing cfg_dma_en during a transfer ends it. The end of a transfer by count on an IN endpoint also pulses pkt_commit.
- R9: The eot_cause bits are bit 0 disable, bit 1 external EOT, bit 2 count and bit 3 short packet. When several sources fire together, only the first present in the order disable, external, count, short is recorded and acted on.
- R10: eot_cause bits are sticky. Writing 1 to a cause_clr bit clears that bit, and a 0 leaves it unchanged.
- R11: dreq is 0 from the clock edge that follows any termination, and fifo_flush and pkt_commit are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dma_en | input | 1 | DMA enable |
| cfg_cnt_en | input | 1 | End the transfer when the count reaches zero |
| cfg_short_en | input | 1 | End an OUT transfer on a short packet |
| cfg_dir_in | input | 1 | 1 = IN endpoint (host writes), 0 = OUT endpoint (host reads) |
| cfg_wide | input | 1 | 1 = 2-byte bus, 0 = 1-byte bus |
| cfg_ack_strobe | input | 1 | 1 = dack alone is the data strobe |
| xfer_len | input | CNT_W | Transfer length in bytes |
| cause_clr | input | 4 | Write-1-to-clear for eot_cause |
| ext_eot | input | 1 | Asynchronous external end-of-transfer |
| dack | input | 1 | DMA acknowledge |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| short_pkt | input | 1 | Short packet received on the endpoint |
| dbl_buf | input | 1 | Endpoint is double-buffered |
| act_buf | input | 1 | Index of the active buffer |
| dreq | output | 1 | DMA request |
| data_strobe | output | 1 | One pulse per counted beat |
| fifo_flush | output | 1 | Flush pulse for an OUT endpoint |
| flush_buf | output | 2 | One-hot buffer to flush |
| pkt_commit | output | 1 | Commit-packet pulse for an IN endpoint |
| eot_cause | output | 4 | Sticky termination cause |
| cnt_left | output | CNT_W | Bytes remaining |

## Verification
The counter is driven with random lengths, bus widths, directions and strobe modes. Each beat's remaining count is compared with a reference model, so both the step size and saturation at zero are checked. Directed strobe patterns apply acknowledge alone, acknowledge with the wrong-direction line, and read/write without acknowledge, which shows which mode counts which strobe. Single sources, a held-high external EOT, and pairs that fire in the same cycle separate the flush, commit and priority paths. Single- and double-buffer flushes are compared by the buffer mask they produce.

// File: rtl/dma_eot_ctrl.sv
module dma_eot_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dma_en,
  input  logic             cfg_cnt_en,
  input  logic             cfg_short_en,
  input  logic             cfg_dir_in,
  input  logic             cfg_wide,
  input  logic             cfg_ack_strobe,
  input  logic [CNT_W-1:0] xfer_len,
  input  logic [3:0]       cause_clr,
  input  logic             ext_eot,
  input  logic             dack,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic             short_pkt,
  input  logic             dbl_buf,
  input  logic             act_buf,
  output logic             dreq,
  output logic             data_strobe,
  output logic             fifo_flush,
  output logic [1:0]       flush_buf,
  output logic             pkt_commit,
  output logic [3:0]       eot_cause,
  output logic [CNT_W-1:0] cnt_left
);
  localparam int C_DIS = 0;
  localparam int C_EXT = 1;
  localparam int C_CNT = 2;
  localparam int C_SHP = 3;
  localparam logic [CNT_W-1:0] ONE = 1;
  localparam logic [CNT_W-1:0] TWO = 2;

  logic             run, en_q, stb_q;
  logic [2:0]       eot_sync;
  logic [3:0]       src, win;
  logic             term, stb, beat, start;
  logic [CNT_W-1:0] step, cnt_nxt;

  assign start = cfg_dma_en & ~en_q & ~run;
  assign stb   = cfg_ack_strobe ? dack : dack & (cfg_dir_in ? host_wr : host_rd);

  assign src[C_DIS] = run & ~cfg_dma_en;
  assign src[C_EXT] = run & eot_sync[1] & ~eot_sync[2];
  assign src[C_CNT] = run & cfg_cnt_en & (cnt_left == '0);
  assign src[C_SHP] = run & cfg_short_en & ~cfg_dir_in & short_pkt;
  assign term = |src;

  always_comb begin
    win = '0;
    if (src[C_DIS])      win[C_DIS] = 1'b1;
    else if (src[C_EXT]) win[C_EXT] = 1'b1;
    else if (src[C_CNT]) win[C_CNT] = 1'b1;
    else if (src[C_SHP]) win[C_SHP] = 1'b1;
  end

  assign beat    = run & ~term & stb & ~stb_q;
  assign step    = cfg_wide ? TWO : ONE;
  assign cnt_nxt = (cnt_left < step) ? '0 : cnt_left - step;

  assign dreq        = run;
  assign data_strobe = beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= 1'b0;
      en_q       <= 1'b0;
      stb_q      <= 1'b0;
      eot_sync   <= '0;
      cnt_left   <= '0;
      eot_cause  <= '0;
      fifo_flush <= 1'b0;
      flush_buf  <= '0;
      pkt_commit <= 1'b0;
    end else begin
      en_q     <= cfg_dma_en;
      stb_q    <= stb;
      eot_sync <= {eot_sync[1:0], ext_eot};
      if (start) begin
        run      <= 1'b1;
        cnt_left <= xfer_len;
      end else if (term) begin
        run <= 1'b0;
      end else if (beat) begin
        cnt_left <= cnt_nxt;
      end
      eot_cause  <= (eot_cause & ~cause_clr) | win;
      fifo_flush <= win[C_EXT] & ~cfg_dir_in;
      flush_buf  <= (win[C_EXT] & ~cfg_dir_in) ?
                    ((dbl_buf & act_buf) ? 2'b10 : 2'b01) : 2'b00;
      pkt_commit <= (win[C_EXT] | win[C_CNT]) & cfg_dir_in;
    end
  end
endmodule

// File: rtl/dma_eot_ctrl_chk.sv
module dma_eot_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dreq,
  input logic             data_strobe,
  input logic             fifo_flush,
  input logic             pkt_commit,
  input logic             cfg_dma_en,
  input logic             cfg_dir_in,
  input logic             cfg_wide,
  input logic [CNT_W-1:0] cnt_left,
  input logic             term_evt
);
  localparam logic [CNT_W-1:0] ONE = 1;
  localparam logic [CNT_W-1:0] TWO = 2;

  p_dreq_after_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dreq) |-> $past(cfg_dma_en));

  p_dec_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_strobe && !cfg_wide && cnt_left >= ONE) |=> (cnt_left == $past(cnt_left) - ONE));

  p_dec_wide_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_strobe && cfg_wide && cnt_left >= TWO) |=> (cnt_left == $past(cnt_left) - TWO));

  p_dreq_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    term_evt |=> !dreq);

  p_flush_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> (!dreq && $past(!cfg_dir_in)));

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_flush && pkt_commit));
endmodule

bind dma_eot_ctrl dma_eot_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dreq(dreq), .data_strobe(data_strobe),
  .fifo_flush(fifo_flush), .pkt_commit(pkt_commit), .cfg_dma_en(cfg_dma_en),
  .cfg_dir_in(cfg_dir_in), .cfg_wide(cfg_wide), .cnt_left(cnt_left),
  .term_evt(term)
);

// File: tb/tb_dma_eot_ctrl.sv
`timescale 1ns/1ps
module tb_dma_eot_ctrl;
  logic clk = 0, rst_n = 0;
  logic en = 0, cnt_en = 0, short_en = 0, dir_in = 0, wide = 0, ack_mode = 0;
  logic [15:0] len = 0;
  logic [3:0] clr = 0;
  logic ext = 0, dack = 0, rd = 0, wr = 0, shp = 0, dbl = 0, abuf = 0;
  logic dreq, dstb, flush, commit;
  logic [1:0] fbuf;
  logic [3:0] cause;
  logic [15:0] cnt;
  int checks = 0, fails = 0, n_flush = 0, n_commit = 0;
  logic [1:0] last_mask = 0;

  dma_eot_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_dma_en(en), .cfg_cnt_en(cnt_en),
    .cfg_short_en(short_en), .cfg_dir_in(dir_in), .cfg_wide(wide),
    .cfg_ack_strobe(ack_mode), .xfer_len(len), .cause_clr(clr),
    .ext_eot(ext), .dack(dack), .host_rd(rd), .host_wr(wr),
    .short_pkt(shp), .dbl_buf(dbl), .act_buf(abuf), .dreq(dreq),
    .data_strobe(dstb), .fifo_flush(flush), .flush_buf(fbuf),
    .pkt_commit(commit), .eot_cause(cause), .cnt_left(cnt)
  );

  always #4 clk = ~clk;

  always @(posedge clk) if (rst_n) begin
    if (flush) begin n_flush++; last_mask = fbuf; end
    if (commit) n_commit++;
  end

  function automatic logic [15:0] exp_next(input logic [15:0] c, input logic w);
    logic [15:0] s = w ? 16'd2 : 16'd1;
    return (c < s) ? 16'd0 : c - s;
  endfunction

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input logic [15:0] l, input logic ce, input logic se,
                       input logic di, input logic w, input logic am);
    len = l; cnt_en = ce; short_en = se; dir_in = di; wide = w; ack_mode = am;
    clr = 4'hF; en = 1;
    @(negedge clk);
    clr = 0;
  endtask

  task automatic stop();
    en = 0;
    idle(2);
  endtask

  task automatic beat(input logic d, input logic r, input logic w);
    dack = d; rd = r; wr = w;
    @(negedge clk);
    dack = 0; rd = 0; wr = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int fl0, cm0;
    logic [15:0] m;
    void'($urandom(32'd1181));
    idle(2);
    chk("R1 dreq", dreq, 0); chk("R1 cause", cause, 0);
    chk("R1 cnt", cnt, 0); chk("R1 flush", {flush, fbuf, commit, dstb}, 0);
    rst_n = 1;
    idle(2);

    // R2 load, R4 strobe selection
    start(16'd100, 1, 0, 0, 0, 0);
    chk("R2 dreq", dreq, 1); chk("R2 load", cnt, 100);
    beat(1, 0, 0); chk("R4 dack alone ignored", cnt, 100);
    beat(1, 0, 1); chk("R4 wrong dir ignored", cnt, 100);
    beat(1, 1, 0); chk("R4 dack+rd counts", cnt, 99);
    ack_mode = 1;
    beat(1, 0, 0); chk("R4 ack-only dack counts", cnt, 98);
    beat(0, 1, 1); chk("R4 ack-only rd/wr ignored", cnt, 98);
    stop();
    chk("R8 disable cause", cause, 4'b0001); chk("R8 dreq", dreq, 0);

    // R2 reload
    start(16'd7, 1, 0, 1, 0, 0);
    chk("R2 reload", cnt, 7);
    stop();

    // R3 wide saturation, R8 count commit on IN
    cm0 = n_commit;
    start(16'd3, 1, 0, 1, 1, 0);
    beat(1, 0, 1); chk("R3 wide dec", cnt, 1);
    beat(1, 0, 1); chk("R3 saturate", cnt, 0);
    chk("R11 dreq after count", dreq, 0); chk("R5 cause", cause, 4'b0100);
    idle(2); chk("R8 count commit IN", n_commit - cm0, 1);
    stop();

    // R10 write-1-to-clear
    clr = 4'b1000; @(negedge clk); clr = 0;
    chk("R10 other bit kept", cause, 4'b0100);
    clr = 4'b0100; @(negedge clk); clr = 0;
    chk("R10 cleared", cause, 0);

    // R5 zero length
    start(16'd0, 1, 0, 0, 0, 0);
    @(negedge clk);
    chk("R5 zero immediate", dreq, 0); chk("R5 zero cause", cause, 4'b0100);
    stop();
    start(16'd0, 0, 0, 0, 0, 0);
    idle(3);
    chk("R5 no count end", dreq, 1);
    stop();

    // R6 external EOT, OUT single buffer, held high
    fl0 = n_flush; dbl = 0; abuf = 1;
    start(16'd50, 1, 0, 0, 0, 0);
    ext = 1; idle(4);
    chk("R6 ext dreq", dreq, 0); chk("R6 ext cause", cause, 4'b0010);
    idle(2);
    chk("R6 flush once", n_flush - fl0, 1); chk("R6 single mask", last_mask, 2'b01);
    stop();
    start(16'd50, 1, 0, 0, 0, 0);
    idle(5);
    chk("R6 held high no new event", dreq, 1);
    ext = 0; stop(); idle(2);

    // R6 double buffer
    fl0 = n_flush; dbl = 1; abuf = 1;
    start(16'd50, 1, 0, 0, 0, 0);
    ext = 1; idle(2); ext = 0; idle(4);
    chk("R6 dbl flush", n_flush - fl0, 1); chk("R6 dbl mask", last_mask, 2'b10);
    stop();

    // R6 IN commit
    fl0 = n_flush; cm0 = n_commit;
    start(16'd50, 1, 0, 1, 0, 0);
    ext = 1; idle(2); ext = 0; idle(4);
    chk("R6 IN commit", n_commit - cm0, 1); chk("R6 IN no flush", n_flush - fl0, 0);
    stop();

    // R7 short packet
    fl0 = n_flush;
    start(16'd50, 1, 1, 0, 0, 0);
    shp = 1; @(negedge clk); shp = 0; @(negedge clk);
    chk("R7 short ends", dreq, 0); chk("R7 cause", cause, 4'b1000);
    chk("R7 no flush", n_flush - fl0, 0);
    stop();
    start(16'd50, 1, 0, 0, 0, 0);
    shp = 1; idle(2); shp = 0;
    chk("R7 disabled ignored", dreq, 1); stop();
    start(16'd50, 1, 1, 1, 0, 0);
    shp = 1; idle(2); shp = 0;
    chk("R7 IN ignored", dreq, 1); stop();

    // R9 priority
    start(16'd0, 1, 1, 0, 0, 0);
    shp = 1; @(negedge clk); shp = 0;
    chk("R9 count over short", cause, 4'b0100); stop();
    start(16'd0, 1, 0, 0, 0, 0);
    en = 0; @(negedge clk);
    chk("R9 disable over count", cause, 4'b0001); idle(2);
    fl0 = n_flush;
    start(16'd50, 1, 0, 0, 0, 0);
    ext = 1; idle(2); en = 0; @(negedge clk); ext = 0;
    chk("R9 disable over ext", cause, 4'b0001);
    idle(3); chk("R9 no flush", n_flush - fl0, 0);

    // R3 random
    for (int t = 0; t < 40; t++) begin
      logic w = 1'($urandom);
      logic d = 1'($urandom);
      logic am = 1'($urandom);
      cm0 = n_commit;
      m = 16'($urandom_range(1, 40));
      start(m, 1, 0, d, w, am);
      while (m != 0) begin
        beat(1, ~d, d);
        m = exp_next(m, w);
        chk("R3 random count", cnt, m);
      end
      chk("R5 random end", dreq, 0);
      chk("R5 random cause", cause, 4'b0100);
      idle(2);
      chk("R8 random commit", n_commit - cm0, d ? 1 : 0);
      stop();
    end
    summary();
  end
endmodule